// File: doc/BRIEF.md
# Hardware Address Breakpoint Unit

This block watches the processor's memory traffic and asks the core to stop when a chosen address is touched. It holds two 16-bit address registers and a small control register. Each cycle it compares the data access address against the two registers, but only when the access is a read or a write of a kind the control register has enabled. It compares the instruction fetch address in the same way when fetch watching is enabled. Either register can therefore act as an instruction breakpoint or as a data watchpoint.

When the build includes the window option, one control bit changes the comparison. A hit then occurs for any address between the two registers, with both ends counted, instead of only for an exact match. A match sends a halt request pulse to the core and sets a sticky pending flag. Debug software reads the flag through the register port and clears it by writing a one.

A debug host programs the unit through a simple register port: a write strobe, a 2-bit select, write data and combinational read data. The host transport and the mechanics of halting the core lie outside this block.

Top module: `brk_unit`

## Requirements
- R1: After reset the control register, both address registers and the pending flag read as zero, and `halt_req` is low.
- R2: The select value picks a register: 0 is control (bits 4:0), 1 is status (bit 0 is the pending flag), 2 is address A and 3 is address B. A write takes effect at the next clock edge. Read data is combinational, and unused bits read as zero.
- R3: With window mode off, an access hits when its address equals address A or address B.
- R4: A data access takes part only if it is a read with control bit 0 set or a write with control bit 1 set. A fetch takes part only if control bit 3 is set. An access that does not qualify never hits.
- R5: While control bit 2 (unit enable) is clear, no access hits, `halt_req` stays low and the pending flag is not set.
- R6: When `RANGE_EN` is 1 and control bit 4 is set, an access hits when A <= address <= B, with both ends counted.
- R7: In window mode, if A > B then no address hits.
- R8: When `RANGE_EN` is 0, control bit 4 is not stored, reads as zero and has no effect, so exact comparison is always used.
- R9: `halt_req` is high for exactly the one cycle that follows each clock cycle holding a hitting access, and is low otherwise.
- R10: A hit sets the pending flag. The flag stays set until a status write with data bit 0 equal to 1. A status write with bit 0 equal to 0 leaves it unchanged.
- R11: If a hit and a clearing status write occur in the same cycle, the pending flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | AW | Register write data |
| cfg_rdata | output | AW | Register read data (combinational) |
| mon_rd | input | 1 | Data read strobe this cycle |
| mon_wr | input | 1 | Data write strobe this cycle |
| mon_daddr | input | AW | Data access address |
| mon_fetch | input | 1 | Instruction fetch strobe this cycle |
| mon_faddr | input | AW | Instruction fetch address |
| halt_req | output | 1 | One-cycle halt request after a hit |

## Verification
The assertions assume that each cycle with a strobe high is one separate access. They also assume that address and control values are stable between clock edges, because both are sampled only at the edge. The stimulus changes every input half a cycle away from the active edge. It always follows an access cycle with an idle cycle, so each expected pulse can be told apart from its neighbour. Register rewrites happen only in cycles with no bus access, except in the one deliberate case that tests set-over-clear priority.

// File: rtl/brk_pkg.sv
package brk_pkg;

    localparam int CTL_W = 5;

    typedef enum logic [1:0] {
        SEL_CTL   = 2'd0,
        SEL_STAT  = 2'd1,
        SEL_ADDRA = 2'd2,
        SEL_ADDRB = 2'd3
    } brk_sel_e;

    // packed MSB first: win is bit 4, rd is bit 0
    typedef struct packed {
        logic win;
        logic fetch;
        logic en;
        logic wr;
        logic rd;
    } brk_ctl_t;

endpackage

// File: rtl/brk_cmp.sv
module brk_cmp #(
    parameter int AW       = 16,
    parameter bit RANGE_EN = 1'b1
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lim_a,
    input  logic [AW-1:0] lim_b,
    input  logic          win_sel,
    output logic          match
);
    logic win_on;

    generate
        if (RANGE_EN) begin : g_win
            assign win_on = win_sel;
        end else begin : g_nowin
            logic unused_win;
            assign unused_win = win_sel;
            assign win_on     = 1'b0;
        end
    endgenerate

    always_comb begin
        if (win_on) match = (addr >= lim_a) && (addr <= lim_b);
        else        match = (addr == lim_a) || (addr == lim_b);
    end
endmodule

// File: rtl/brk_regs.sv
module brk_regs
    import brk_pkg::*;
#(
    parameter int AW       = 16,
    parameter bit RANGE_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          hit,
    output brk_ctl_t      ctl,
    output logic [AW-1:0] addr_a,
    output logic [AW-1:0] addr_b,
    output logic          halt,
    output logic [AW-1:0] cfg_rdata
);
    typedef struct packed {
        brk_ctl_t      ctl;
        logic [AW-1:0] a;
        logic [AW-1:0] b;
        logic          pend;
        logic          halt;
    } st_t;

    st_t st_d, st_q;
    brk_sel_e sel;
    logic clr_wr;
    logic unused_wdata;

    assign sel          = brk_sel_e'(cfg_sel);
    assign clr_wr       = cfg_wr && (sel == SEL_STAT) && cfg_wdata[0];
    assign unused_wdata = &{1'b0, cfg_wdata[AW-1:CTL_W]};

    always_comb begin
        st_d      = st_q;
        st_d.halt = hit;
        if (cfg_wr) begin
            unique case (sel)
                SEL_CTL: begin
                    st_d.ctl = brk_ctl_t'(cfg_wdata[CTL_W-1:0]);
                    if (!RANGE_EN) st_d.ctl.win = 1'b0;
                end
                SEL_STAT:  if (cfg_wdata[0]) st_d.pend = 1'b0;
                SEL_ADDRA: st_d.a = cfg_wdata;
                SEL_ADDRB: st_d.b = cfg_wdata;
                default:   ;
            endcase
        end
        if (hit) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (sel)
            SEL_CTL:   cfg_rdata[CTL_W-1:0] = st_q.ctl;
            SEL_STAT:  cfg_rdata[0] = st_q.pend;
            SEL_ADDRA: cfg_rdata = st_q.a;
            SEL_ADDRB: cfg_rdata = st_q.b;
            default:   cfg_rdata = '0;
        endcase
    end

    assign ctl    = st_q.ctl;
    assign addr_a = st_q.a;
    assign addr_b = st_q.b;
    assign halt   = st_q.halt;

    // R10: the flag holds unless a clearing write arrives
    p_pend_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend && !clr_wr |=> st_q.pend);
    // R10: a clearing write with no hit empties the flag
    p_pend_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && !hit |=> !st_q.pend);
    // R11 and R9: a hit yields a pulse and a set flag, even against a clear
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> st_q.pend && st_q.halt);
endmodule

// File: rtl/brk_unit.sv
module brk_unit
    import brk_pkg::*;
#(
    parameter int AW       = 16,
    parameter bit RANGE_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] cfg_rdata,
    input  logic          mon_rd,
    input  logic          mon_wr,
    input  logic [AW-1:0] mon_daddr,
    input  logic          mon_fetch,
    input  logic [AW-1:0] mon_faddr,
    output logic          halt_req
);
    localparam int NPORT = 2;

    brk_ctl_t      ctl;
    logic [AW-1:0] addr_a, addr_b;
    logic [AW-1:0] port_addr [NPORT];
    logic [NPORT-1:0] port_qual, port_match;
    logic hit;

    assign port_addr[0] = mon_daddr;
    assign port_addr[1] = mon_faddr;
    assign port_qual[0] = (mon_rd && ctl.rd) || (mon_wr && ctl.wr);
    assign port_qual[1] = mon_fetch && ctl.fetch;

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            brk_cmp #(.AW(AW), .RANGE_EN(RANGE_EN)) u_cmp (
                .addr    (port_addr[p]),
                .lim_a   (addr_a),
                .lim_b   (addr_b),
                .win_sel (ctl.win),
                .match   (port_match[p])
            );
        end
    endgenerate

    assign hit = ctl.en && |(port_qual & port_match);

    brk_regs #(.AW(AW), .RANGE_EN(RANGE_EN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .hit       (hit),
        .ctl       (ctl),
        .addr_a    (addr_a),
        .addr_b    (addr_b),
        .halt      (halt_req),
        .cfg_rdata (cfg_rdata)
    );

    // R5: a disabled unit never requests a halt
    p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.en |=> !halt_req);
    // R3: an enabled exact read match on address A requests a halt
    p_exact_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.en && ctl.rd && !ctl.win && mon_rd && (mon_daddr == addr_a) |=> halt_req);

    generate
        if (RANGE_EN) begin : g_win_chk
            // R7: an inverted window matches nothing
            p_inverted_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
                ctl.win && (addr_a > addr_b) |=> !halt_req);
        end
    endgenerate
endmodule

// File: tb/tb_brk_unit.sv
module tb_brk_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = '0;
    logic mon_rd = 1'b0, mon_wr = 1'b0, mon_fetch = 1'b0;
    logic [15:0] mon_daddr = '0, mon_faddr = '0;
    logic [15:0] rdata, rdata_nr;
    logic halt, halt_nr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct { bit e; bit enr; string tag; } item_t;
    item_t q[$];

    always #5 clk = ~clk;

    brk_unit #(.AW(16), .RANGE_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdata), .mon_rd(mon_rd),
        .mon_wr(mon_wr), .mon_daddr(mon_daddr), .mon_fetch(mon_fetch),
        .mon_faddr(mon_faddr), .halt_req(halt));

    brk_unit #(.AW(16), .RANGE_EN(1'b0)) dut_nr (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_nr), .mon_rd(mon_rd),
        .mon_wr(mon_wr), .mon_daddr(mon_daddr), .mon_fetch(mon_fetch),
        .mon_faddr(mon_faddr), .halt_req(halt_nr));

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pop one expectation per edge after the output settles
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            chk({it.tag, " halt"}, {15'd0, halt}, {15'd0, it.e});
            chk({it.tag, " halt_nr"}, {15'd0, halt_nr}, {15'd0, it.enr});
        end
    end

    task automatic wreg(logic [1:0] s, logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rchk(logic [1:0] s, logic [15:0] e, logic [15:0] enr, string tag);
        @(negedge clk);
        cfg_sel = s;
        #1;
        chk({tag, " rdata"}, rdata, e);
        chk({tag, " rdata_nr"}, rdata_nr, enr);
    endtask

    task automatic access(bit r, bit w, bit f, logic [15:0] da, logic [15:0] fa,
                          bit e, bit enr, string tag);
        @(negedge clk);
        mon_rd = r; mon_wr = w; mon_fetch = f; mon_daddr = da; mon_faddr = fa;
        q.push_back('{e, enr, tag});
        @(negedge clk);
        mon_rd = 1'b0; mon_wr = 1'b0; mon_fetch = 1'b0;
        q.push_back('{1'b0, 1'b0, "R9 pulse end"});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 halt in reset", {15'd0, halt}, 16'd0);
        for (int s = 0; s < 4; s++) rchk(s[1:0], 16'h0, 16'h0, "R1 reset read");
        @(negedge clk);
        rst_n = 1'b1;

        // R2: address registers
        wreg(2'd2, 16'h1200);
        wreg(2'd3, 16'h12F0);
        rchk(2'd2, 16'h1200, 16'h1200, "R2 addr A");
        rchk(2'd3, 16'h12F0, 16'h12F0, "R2 addr B");

        // enable + read
        wreg(2'd0, 16'h0005);
        rchk(2'd0, 16'h0005, 16'h0005, "R2 ctl");
        access(1, 0, 0, 16'h1200, 16'h0, 1, 1, "R3 read A");
        access(1, 0, 0, 16'h12F0, 16'h0, 1, 1, "R3 read B");
        access(1, 0, 0, 16'h1201, 16'h0, 0, 0, "R3 read miss");
        access(0, 1, 0, 16'h1200, 16'h0, 0, 0, "R4 write unqualified");
        access(0, 0, 1, 16'h0, 16'h1200, 0, 0, "R4 fetch unqualified");

        // enable + write
        wreg(2'd0, 16'h0006);
        access(0, 1, 0, 16'h12F0, 16'h0, 1, 1, "R4 write B");
        access(1, 0, 0, 16'h12F0, 16'h0, 0, 0, "R4 read unqualified");

        // enable + fetch
        wreg(2'd0, 16'h000C);
        access(0, 0, 1, 16'h0, 16'h1200, 1, 1, "R4 fetch A");
        access(1, 0, 0, 16'h1200, 16'h0, 0, 0, "R4 data vs fetch");

        // R10 clear, then R5 disabled
        rchk(2'd1, 16'h1, 16'h1, "R10 pending set");
        wreg(2'd1, 16'h0001);
        rchk(2'd1, 16'h0, 16'h0, "R10 cleared");
        wreg(2'd0, 16'h000B);
        access(1, 0, 1, 16'h1200, 16'h1200, 0, 0, "R5 disabled");
        rchk(2'd1, 16'h0, 16'h0, "R5 pending untouched");

        // window mode
        wreg(2'd0, 16'h0015);
        rchk(2'd0, 16'h0015, 16'h0005, "R8 win bit readback");
        access(1, 0, 0, 16'h1200, 16'h0, 1, 1, "R6 low end");
        access(1, 0, 0, 16'h12F0, 16'h0, 1, 1, "R6 high end");
        access(1, 0, 0, 16'h1250, 16'h0, 1, 0, "R6 R8 inside");
        access(1, 0, 0, 16'h11FF, 16'h0, 0, 0, "R6 below");
        access(1, 0, 0, 16'h12F1, 16'h0, 0, 0, "R6 above");

        // inverted window
        wreg(2'd2, 16'h3000);
        wreg(2'd3, 16'h2000);
        access(1, 0, 0, 16'h2800, 16'h0, 0, 0, "R7 inverted middle");
        access(1, 0, 0, 16'h3000, 16'h0, 0, 1, "R7 R8 inverted A");
        access(1, 0, 0, 16'h2000, 16'h0, 0, 1, "R7 R8 inverted B");

        // R10 write of zero, R11 priority
        wreg(2'd0, 16'h0005);
        wreg(2'd1, 16'h0000);
        rchk(2'd1, 16'h1, 16'h1, "R10 zero write ignored");
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 2'd1; cfg_wdata = 16'h0001;
        mon_rd = 1'b1; mon_daddr = 16'h3000;
        q.push_back('{1'b1, 1'b1, "R11 hit with clear"});
        @(negedge clk);
        cfg_wr = 1'b0; mon_rd = 1'b0;
        q.push_back('{1'b0, 1'b0, "R9 pulse end"});
        rchk(2'd1, 16'h1, 16'h1, "R11 set wins");
        wreg(2'd1, 16'h0001);
        rchk(2'd1, 16'h0, 16'h0, "R10 final clear");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule